// File: doc/BRIEF.md
# Distributed Rotating-Priority Bus Arbiter

This block is the arbitration logic that sits inside each agent of a shared-bus cluster of up to six agents. No central arbiter exists. Every agent watches the full set of request lines and works out the same answer by itself: which agent owns the bus, whether the local agent is that owner, and whether the current cycle is a bus transition cycle. Each agent drives only the request line that matches its own ID. All copies of the block see the same line values, so they reach the same decision in lockstep.

An owner keeps the bus for as long as its own request stays asserted. Ownership moves only when the owner drops its request while some other agent is asking for the bus. That cycle is the transition cycle, and the chosen requester owns the bus on the next cycle. A mode input selects the priority scheme. Fixed priority always favours the lowest ID. Rotating priority restarts the order just after each new owner.

Top module: `dist_bus_arbiter`

## Requirements
- R1: Request bit k of `req_i` belongs to agent ID k+1 (IDs 1 to `N_AGENTS`). `grant_o` is 1 exactly when `master_id_o` equals the `LOCAL_ID` parameter.
- R2: While `rst_ni` is low, `master_id_o` is 0, which encodes "no owner", and `grant_o` is 0. After reset, with no requests, `transition_o` stays 0.
- R3: While the current owner's request bit is 1, `master_id_o` keeps its value, whatever the other lines do.
- R4: `transition_o` is 1 in a cycle when there is no owner, or the owner's request bit is 0, and at least one request bit is 1. On the next clock edge `master_id_o` takes the ID of the chosen requester.
- R5: When the owner drops its request and no other line is asserted, `transition_o` stays 0 and `master_id_o` keeps the parked owner. If that owner asserts its request again, it holds the bus with no transition cycle.
- R6: With `rotate_i` = 0 (fixed mode), the lowest-numbered requesting ID is chosen.
- R7: With `rotate_i` = 1 (rotating mode), after agent X becomes owner, the search order starts at X+1 and rises by ID, wrapping from `N_AGENTS` to 1.
- R8: After reset, the rotating order starts with ID 1 as highest priority.
- R9: A request line held at 0, for example the line of an unpopulated agent, is never chosen as owner.
- R10: All agents on the same request lines report the same `master_id_o` and `transition_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rotate_i | input | 1 | 1 = rotating priority, 0 = fixed priority |
| req_i | input | N_AGENTS | Shared request lines. Bit k is the line of ID k+1 |
| grant_o | output | 1 | The local agent currently owns the bus |
| master_id_o | output | $clog2(N_AGENTS+1) | ID of the current owner. 0 = none |
| transition_o | output | 1 | The current cycle is a bus transition cycle |

## Verification
Two functions can fall in the same cycle: the owner releasing the bus and the other agents asking for it. When both happen together, that cycle becomes a transition cycle. The bench provokes this by dropping the owner's bit and raising other bits in the same step. It uses sets of competitors that are picked so the fixed and rotating orders give different winners, including a wrap past the top ID onto a line that is never driven. The bench judges each such step against a reference model built from the requirements. The model covers the transition flag in that cycle, the new owner one cycle later, and the agreement across six instances that each have a different local ID.

// File: rtl/dba_pkg.sv
package dba_pkg;

  typedef enum logic {
    MODE_FIXED  = 1'b0,
    MODE_ROTATE = 1'b1
  } arb_mode_e;

  // ring successor of a 1-based ID
  function automatic int unsigned ring_next(input int unsigned id, input int unsigned n);
    return (id >= n) ? 1 : id + 1;
  endfunction

endpackage

// File: rtl/dba_pick.sv
module dba_pick #(
  parameter int unsigned N_AGENTS = 6,
  parameter int unsigned IDW      = $clog2(N_AGENTS + 1)
) (
  input  logic [N_AGENTS-1:0] req_i,
  input  logic [IDW-1:0]      base_id_i,
  output logic                any_o,
  output logic [IDW-1:0]      win_id_o
);

  always_comb begin
    int unsigned start;
    logic        found;
    start    = (int'(base_id_i) > 0) ? int'(base_id_i) - 1 : 0;
    found    = 1'b0;
    win_id_o = '0;
    for (int unsigned k = 0; k < N_AGENTS; k++) begin
      int unsigned idx;
      idx = (start + k) % N_AGENTS;
      if (!found && req_i[idx]) begin
        found    = 1'b1;
        win_id_o = IDW'(idx + 1);
      end
    end
  end

  assign any_o = |req_i;

endmodule

// File: rtl/dba_prio_base.sv
module dba_prio_base
  import dba_pkg::*;
#(
  parameter int unsigned N_AGENTS = 6,
  parameter int unsigned IDW      = $clog2(N_AGENTS + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  arb_mode_e      mode_i,
  input  logic           adv_i,
  input  logic [IDW-1:0] win_id_i,
  output logic [IDW-1:0] base_id_o
);

  logic [IDW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= IDW'(1);
    end else if (adv_i && mode_i == MODE_ROTATE) begin
      ptr_q <= IDW'(ring_next(int'(win_id_i), N_AGENTS));
    end
  end

  assign base_id_o = (mode_i == MODE_ROTATE) ? ptr_q : IDW'(1);

  AST_BASE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (base_id_o != '0) && (int'(base_id_o) <= N_AGENTS)); // R7

endmodule

// File: rtl/dba_master_track.sv
module dba_master_track #(
  parameter int unsigned N_AGENTS = 6,
  parameter int unsigned IDW      = $clog2(N_AGENTS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_AGENTS-1:0] req_i,
  input  logic                any_i,
  input  logic [IDW-1:0]      win_id_i,
  output logic [IDW-1:0]      master_id_o,
  output logic                transition_o
);

  localparam int unsigned EXT_W = 2 ** IDW;

  logic [IDW-1:0]   master_q;
  logic [EXT_W-1:0] req_ext;
  logic             master_req;

  // bit 0 stands for "no owner" and is always 0
  assign req_ext      = EXT_W'({req_i, 1'b0});
  assign master_req   = req_ext[master_q];
  assign transition_o = !master_req && any_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= '0;
    end else if (transition_o) begin
      master_q <= win_id_i;
    end
  end

  assign master_id_o = master_q;

  AST_OWNER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_req |=> $stable(master_id_o)); // R3

  AST_QUIET_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !transition_o |=> $stable(master_id_o)); // R5

  AST_WIN_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    transition_o |-> (win_id_i != '0) && req_ext[win_id_i]); // R9

  AST_NEW_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    transition_o |=> master_id_o != '0); // R4

endmodule

// File: rtl/dist_bus_arbiter.sv
module dist_bus_arbiter
  import dba_pkg::*;
#(
  parameter int unsigned N_AGENTS = 6,
  parameter int unsigned LOCAL_ID = 1,
  localparam int unsigned IDW     = $clog2(N_AGENTS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rotate_i,
  input  logic [N_AGENTS-1:0] req_i,
  output logic                grant_o,
  output logic [IDW-1:0]      master_id_o,
  output logic                transition_o
);

  arb_mode_e      mode;
  logic [IDW-1:0] base_id;
  logic [IDW-1:0] win_id;
  logic           any_req;

  assign mode = arb_mode_e'(rotate_i);

  dba_pick #(.N_AGENTS(N_AGENTS), .IDW(IDW)) i_pick (
    .req_i     (req_i),
    .base_id_i (base_id),
    .any_o     (any_req),
    .win_id_o  (win_id)
  );

  dba_prio_base #(.N_AGENTS(N_AGENTS), .IDW(IDW)) i_prio_base (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .adv_i     (transition_o),
    .win_id_i  (win_id),
    .base_id_o (base_id)
  );

  dba_master_track #(.N_AGENTS(N_AGENTS), .IDW(IDW)) i_track (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .any_i        (any_req),
    .win_id_i     (win_id),
    .master_id_o  (master_id_o),
    .transition_o (transition_o)
  );

  assign grant_o = (master_id_o == IDW'(LOCAL_ID));

  AST_FIXED_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rotate_i && transition_o) |->
      ((req_i & ((N_AGENTS'(1) << (win_id - IDW'(1))) - N_AGENTS'(1))) == '0)); // R6

  AST_GRANT_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(grant_o) |-> $past(transition_o)); // R1

endmodule

// File: tb/test_dist_bus_arbiter.sv
module test_dist_bus_arbiter;
  localparam int N   = 6;
  localparam int IDW = $clog2(N + 1);

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         rotate = 1'b0;
  logic [N-1:0] req = '0;

  always #4 clk = ~clk;  // 125 MHz

  logic [IDW-1:0] mid [N];
  logic [N-1:0]   gnt;
  logic [N-1:0]   trn;

  for (genvar g = 0; g < N; g++) begin : g_agent
    dist_bus_arbiter #(.N_AGENTS(N), .LOCAL_ID(g + 1)) i_dist_bus_arbiter (
      .clk_i        (clk),
      .rst_ni       (rst_ni),
      .rotate_i     (rotate),
      .req_i        (req),
      .grant_o      (gnt[g]),
      .master_id_o  (mid[g]),
      .transition_o (trn[g])
    );
  end

  typedef struct {
    int       m;
    bit       t;
    bit [N-1:0] g;
    string    tag;
  } exp_t;

  exp_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  int m_mod = 0;
  int p_mod = 1;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of requests, push the expected outputs
  task automatic step(input logic [N-1:0] r, input string tag);
    exp_t e;
    bit   mreq;
    int   base;
    int   w;
    @(negedge clk);
    req   = r;
    mreq  = (m_mod != 0) && r[m_mod-1];
    e.m   = m_mod;
    e.t   = !mreq && (r != '0);
    e.g   = (m_mod != 0) ? (N'(1) << (m_mod - 1)) : '0;
    e.tag = tag;
    q.push_back(e);
    if (e.t) begin
      base = rotate ? p_mod : 1;
      w = 0;
      for (int k = 0; k < N; k++) begin
        int idx;
        idx = (base - 1 + k) % N;
        if (w == 0 && r[idx]) w = idx + 1;
      end
      m_mod = w;
      if (rotate) p_mod = (w % N) + 1;
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_ni = 1'b0;
    req    = '0;
    rotate = mode;
    m_mod  = 0;
    p_mod  = 1;
    #1;
    check(mid[0] == '0 && gnt == '0, "R2", "owner in reset", int'(mid[0]), 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // monitor: compare just before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        bit   agree;
        e = q.pop_front();
        check(int'(mid[0]) == e.m, e.tag, "master_id", int'(mid[0]), e.m);
        check(trn[0] == e.t, e.tag, "transition", int'(trn[0]), int'(e.t));
        check(gnt == e.g, "R1", "grant vector", int'(gnt), int'(e.g));
        agree = 1'b1;
        for (int g = 1; g < N; g++) begin
          if (mid[g] != mid[0] || trn[g] != trn[0]) agree = 1'b0;
        end
        check(agree, "R10", "agents agree", int'(agree), 1);
      end
    end
  end

  initial begin
    // fixed priority
    do_reset(1'b0);
    step(6'b000000, "R2");
    step(6'b000100, "R4");   // ID3 from idle
    step(6'b000101, "R3");   // ID3 holds against ID1
    step(6'b000001, "R4");   // ID3 releases, ID1 takes over
    step(6'b000000, "R5");   // parked on ID1
    step(6'b000001, "R5");   // ID1 back without transition
    step(6'b110000, "R6");   // ID5 and ID6 compete, ID5 wins
    step(6'b100000, "R4");
    step(6'b001010, "R6");   // ID2 and ID4, ID2 wins
    step(6'b000000, "R6");
    step(6'b000000, "R5");
    // rotating priority
    do_reset(1'b1);
    step(6'b101000, "R8");   // ID4 and ID6, order starts at ID1
    step(6'b101001, "R3");
    step(6'b100001, "R7");   // after ID4: ID6 beats ID1
    step(6'b000011, "R7");   // wrap, ID1 highest
    step(6'b011110, "R7");
    step(6'b011100, "R7");
    step(6'b011000, "R7");
    step(6'b010001, "R7");   // ID5
    step(6'b000001, "R9");   // ID6 line idle, wraps to ID1
    step(6'b000000, "R9");
    step(6'b000000, "R5");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule